// File: doc/BRIEF.md
# Read Tag Remapping Manager

This block sits between many request sources and one shared transaction bus. Each source has a unit ID and numbers its own read requests with a local tag. Several sources may use the same local tag at once. The bus needs a single tag space in which every outstanding read has a unique global tag.

On the request side, the block gives each accepted read a free global tag and stores the originating unit ID and local tag against it. When a completion arrives carrying that global tag, the block looks up the stored pair and returns it in the same cycle. The tag goes back into circulation when the completion part marked as last is seen.

The block also keeps a word credit for the completion buffer downstream. A read is accepted only when its whole length in words fits in the credit that remains. The completion side therefore never has to stall. Writes pass straight through and use neither a tag nor credit.

The control is a two-state machine. ST_FILL is entered on reset. In ST_FILL the block loads every global tag value into its free list, one value per cycle. The block moves from ST_FILL to ST_RUN on the cycle that loads the last tag, and stays in ST_RUN until the next reset. In ST_RUN it serves requests and completions.

Top module: `tag_remap_mgr`

## Requirements
- R1: While rst_n is low, up_ready is 0. After rst_n goes high, up_ready stays 0 for exactly TAGS rising edges, which is the ST_FILL state. It is valid from the next cycle onward.
- R2: In ST_RUN, an accepted read (iss_valid=1, iss_is_read=1) carries on iss_gtag a global tag that is not held by any outstanding read. Tags are handed out in first-in, first-out order. After reset the order is 0, 1, …, TAGS-1. After that, each freed tag joins the end of the queue in the order it was released.
- R3: While cpl_valid is 1, cpl_unit and cpl_ltag show, in the same cycle, the unit ID and local tag that were recorded when cpl_gtag was issued. This holds for every part of a completion.
- R4: A completion part with cpl_last=0 does not free its tag. A part with cpl_last=1 frees it, and the tag can be issued again from the next cycle.
- R5: In ST_RUN, a write (up_is_read=0) sees up_ready=1 whatever the tag and credit state. It is issued with iss_gtag=0 and consumes no tag and no credit.
- R6: While all TAGS global tags are outstanding, up_ready is 0 for a read. The request is held by its source and is never dropped.
- R7: The credit starts at BUF_WORDS. An accepted read subtracts up_len (an unsigned word count) from it. A release with rel_valid=1 adds rel_words, and the new value takes effect from the cycle after the release edge. A read whose up_len exceeds the remaining credit sees up_ready=0.
- R8: A read whose up_len is exactly equal to the remaining credit is accepted, provided a tag is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_valid | input | 1 | Request present |
| up_ready | output | 1 | Request can be accepted this cycle |
| up_is_read | input | 1 | 1 = read request, 0 = write |
| up_unit | input | UNIT_W | Unit ID of the requester |
| up_ltag | input | LTAG_W | Local tag of the requester |
| up_len | input | LEN_W | Read length in data words |
| iss_valid | output | 1 | Request issued this cycle |
| iss_is_read | output | 1 | Issued request is a read |
| iss_gtag | output | GTW | Global tag of the issued read, 0 for writes |
| cpl_valid | input | 1 | Completion part present |
| cpl_gtag | input | GTW | Global tag of the completion |
| cpl_last | input | 1 | Final part of the completion |
| cpl_unit | output | UNIT_W | Recovered unit ID |
| cpl_ltag | output | LTAG_W | Recovered local tag |
| rel_valid | input | 1 | Completion words left the buffer |
| rel_words | input | LEN_W | Number of words released |

## Verification
The hardest situation to reach is a full tag table with completions still in progress. It is needed to show that a non-last part leaves the block stalled and that only the last part re-opens it. The stimulus reaches it by issuing one single-word read for every global tag without completing any. It then sends a non-last part and probes ready, sends the last part, and checks that the next read receives exactly that tag.

The exact credit boundary is reached the same way. The full buffer is reserved with one maximum-length read. The bench then checks that a one-word release is seen only on the following cycle.

// File: rtl/tag_remap_pkg.sv
package tag_remap_pkg;

    // Control states of the manager
    typedef enum logic {
        ST_FILL = 1'b0,   // loading every tag value into the free list
        ST_RUN  = 1'b1    // serving requests and completions
    } mgr_state_e;

endpackage

// File: rtl/tag_free_list.sv
module tag_free_list #(
    parameter int DEPTH = 32,
    parameter int W     = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_val,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  slots [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= push_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= adv(wr_ptr);
            if (pop)  rd_ptr <= adv(rd_ptr);
            unique case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign head  = slots[rd_ptr];
    assign empty = (cnt == '0);
endmodule

// File: rtl/tag_map_table.sv
module tag_map_table #(
    parameter int DEPTH = 32,
    parameter int AW    = 5,
    parameter int W     = 12
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] ents [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) ents[wr_addr] <= wr_data;
    end

    assign rd_data = ents[rd_addr];
endmodule

// File: rtl/credit_pool.sv
module credit_pool #(
    parameter int TOTAL = 64,
    parameter int AMT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [AMT_W-1:0] take_amt,
    input  logic             give,
    input  logic [AMT_W-1:0] give_amt,
    input  logic [AMT_W-1:0] need,
    output logic             enough
);
    localparam int CRW = $clog2(TOTAL + 1);
    localparam int SW  = ((CRW > AMT_W) ? CRW : AMT_W) + 1;

    logic [CRW-1:0] avail_q;
    logic [SW-1:0]  nxt;

    always_comb begin
        nxt = SW'(avail_q);
        if (take) nxt = nxt - SW'(take_amt);
        if (give) nxt = nxt + SW'(give_amt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) avail_q <= CRW'(TOTAL);
        else        avail_q <= nxt[CRW-1:0];
    end

    assign enough = (SW'(need) <= SW'(avail_q));
endmodule

// File: rtl/tag_remap_mgr.sv
module tag_remap_mgr
    import tag_remap_pkg::*;
#(
    parameter  int TAGS      = 32,
    parameter  int UNIT_W    = 4,
    parameter  int LTAG_W    = 8,
    parameter  int LEN_W     = 7,
    parameter  int BUF_WORDS = 64,
    localparam int GTW       = $clog2(TAGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic              up_is_read,
    input  logic [UNIT_W-1:0] up_unit,
    input  logic [LTAG_W-1:0] up_ltag,
    input  logic [LEN_W-1:0]  up_len,
    output logic              iss_valid,
    output logic              iss_is_read,
    output logic [GTW-1:0]    iss_gtag,
    input  logic              cpl_valid,
    input  logic [GTW-1:0]    cpl_gtag,
    input  logic              cpl_last,
    output logic [UNIT_W-1:0] cpl_unit,
    output logic [LTAG_W-1:0] cpl_ltag,
    input  logic              rel_valid,
    input  logic [LEN_W-1:0]  rel_words
);
    localparam int ENT_W = UNIT_W + LTAG_W;

    mgr_state_e     state_q;
    logic [GTW-1:0] fill_idx_q;

    logic           fl_push, fl_empty;
    logic [GTW-1:0] fl_push_tag, fl_head;
    logic           cr_enough;
    logic           rd_fire;
    logic [ENT_W-1:0] ent_rd;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_FILL;
            fill_idx_q <= '0;
        end else begin
            unique case (state_q)
                ST_FILL: begin
                    fill_idx_q <= fill_idx_q + 1'b1;
                    if (fill_idx_q == GTW'(TAGS - 1)) state_q <= ST_RUN;
                end
                ST_RUN: state_q <= ST_RUN;
            endcase
        end
    end

    // State outputs
    always_comb begin
        fl_push     = 1'b0;
        fl_push_tag = fill_idx_q;
        up_ready    = 1'b0;
        unique case (state_q)
            ST_FILL: begin
                fl_push     = 1'b1;
                fl_push_tag = fill_idx_q;
                up_ready    = 1'b0;
            end
            ST_RUN: begin
                fl_push     = cpl_valid && cpl_last;
                fl_push_tag = cpl_gtag;
                up_ready    = up_is_read ? (!fl_empty && cr_enough) : 1'b1;
            end
        endcase
    end

    assign rd_fire     = up_valid && up_ready && up_is_read;
    assign iss_valid   = up_valid && up_ready;
    assign iss_is_read = up_is_read;
    assign iss_gtag    = rd_fire ? fl_head : '0;
    assign cpl_unit    = cpl_valid ? ent_rd[ENT_W-1:LTAG_W] : '0;
    assign cpl_ltag    = cpl_valid ? ent_rd[LTAG_W-1:0] : '0;

    tag_free_list #(.DEPTH(TAGS), .W(GTW)) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (fl_push),
        .push_val (fl_push_tag),
        .pop      (rd_fire),
        .head     (fl_head),
        .empty    (fl_empty)
    );

    tag_map_table #(.DEPTH(TAGS), .AW(GTW), .W(ENT_W)) u_map (
        .clk     (clk),
        .wr_en   (rd_fire),
        .wr_addr (fl_head),
        .wr_data ({up_unit, up_ltag}),
        .rd_addr (cpl_gtag),
        .rd_data (ent_rd)
    );

    credit_pool #(.TOTAL(BUF_WORDS), .AMT_W(LEN_W)) u_credit (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (rd_fire),
        .take_amt (up_len),
        .give     (rel_valid),
        .give_amt (rel_words),
        .need     (up_len),
        .enough   (cr_enough)
    );
endmodule

// File: rtl/tag_remap_checker.sv
module tag_remap_checker #(
    parameter  int TAGS      = 32,
    parameter  int LEN_W     = 7,
    parameter  int BUF_WORDS = 64,
    localparam int GTW       = $clog2(TAGS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             up_valid,
    input logic             up_ready,
    input logic             up_is_read,
    input logic [LEN_W-1:0] up_len,
    input logic [GTW-1:0]   iss_gtag,
    input logic             cpl_valid,
    input logic [GTW-1:0]   cpl_gtag,
    input logic             cpl_last,
    input logic             rel_valid,
    input logic [LEN_W-1:0] rel_words
);
    localparam int SCW = $clog2(TAGS + 1);
    localparam int MW  = 16;

    logic [SCW-1:0]  since_rst;
    logic [TAGS-1:0] busy_q, busy_d;
    logic [MW-1:0]   cred_q, cred_d;
    logic            rd_acc;

    assign rd_acc = up_valid && up_ready && up_is_read;

    always_comb begin
        busy_d = busy_q;
        if (rd_acc) busy_d[iss_gtag] = 1'b1;
        if (cpl_valid && cpl_last) busy_d[cpl_gtag] = 1'b0;
        cred_d = cred_q;
        if (rd_acc)    cred_d = cred_d - MW'(up_len);
        if (rel_valid) cred_d = cred_d + MW'(rel_words);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
            busy_q    <= '0;
            cred_q    <= MW'(BUF_WORDS);
        end else begin
            if (since_rst != SCW'(TAGS)) since_rst <= since_rst + 1'b1;
            busy_q <= busy_d;
            cred_q <= cred_d;
        end
    end

    a_r1_fill_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != SCW'(TAGS)) |-> !up_ready);

    a_r2_tag_unique: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |-> !busy_q[iss_gtag]);

    a_r5_write_open: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == SCW'(TAGS) && up_valid && !up_is_read) |-> up_ready);

    a_r6_all_busy_stall: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(busy_q) == TAGS) |-> !(up_ready && up_is_read));

    a_r7_credit_fits: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |-> (MW'(up_len) <= cred_q));
endmodule

bind tag_remap_mgr tag_remap_checker #(
    .TAGS      (TAGS),
    .LEN_W     (LEN_W),
    .BUF_WORDS (BUF_WORDS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_valid   (up_valid),
    .up_ready   (up_ready),
    .up_is_read (up_is_read),
    .up_len     (up_len),
    .iss_gtag   (iss_gtag),
    .cpl_valid  (cpl_valid),
    .cpl_gtag   (cpl_gtag),
    .cpl_last   (cpl_last),
    .rel_valid  (rel_valid),
    .rel_words  (rel_words)
);

// File: tb/test_tag_remap_mgr.sv
module test_tag_remap_mgr;
    localparam int TAGS = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       up_valid = 1'b0, up_ready, up_is_read = 1'b0;
    logic [3:0] up_unit = '0;
    logic [7:0] up_ltag = '0;
    logic [6:0] up_len = '0;
    logic       iss_valid, iss_is_read;
    logic [4:0] iss_gtag;
    logic       cpl_valid = 1'b0, cpl_last = 1'b0;
    logic [4:0] cpl_gtag = '0;
    logic [3:0] cpl_unit;
    logic [7:0] cpl_ltag;
    logic       rel_valid = 1'b0;
    logic [6:0] rel_words = '0;

    int checks = 0;
    int fails  = 0;

    // scoreboard state
    int          free_q[$];
    logic [11:0] req_q[$];
    logic [11:0] map_m [TAGS];
    logic [TAGS-1:0] out_bm = '0;

    always #5 clk = ~clk;

    tag_remap_mgr i_tag_remap_mgr (
        .clk(clk), .rst_n(rst_n),
        .up_valid(up_valid), .up_ready(up_ready), .up_is_read(up_is_read),
        .up_unit(up_unit), .up_ltag(up_ltag), .up_len(up_len),
        .iss_valid(iss_valid), .iss_is_read(iss_is_read), .iss_gtag(iss_gtag),
        .cpl_valid(cpl_valid), .cpl_gtag(cpl_gtag), .cpl_last(cpl_last),
        .cpl_unit(cpl_unit), .cpl_ltag(cpl_ltag),
        .rel_valid(rel_valid), .rel_words(rel_words)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Monitor: compares issued tags and recovered IDs against the model
    initial begin
        for (int i = 0; i < TAGS; i++) free_q.push_back(i);
        forever begin
            @(negedge clk);
            #3;
            if (rst_n) begin
                if (iss_valid && iss_is_read) begin
                    if (free_q.size() > 0 && req_q.size() > 0) begin
                        chk("R2 tag order", int'(iss_gtag), free_q.pop_front());
                        chk("R2 tag not outstanding", int'(out_bm[iss_gtag]), 0);
                        out_bm[iss_gtag] = 1'b1;
                        map_m[iss_gtag]  = req_q.pop_front();
                    end else begin
                        chk("R6 read issued with model empty", 1, 0);
                    end
                end
                if (iss_valid && !iss_is_read)
                    chk("R5 write gtag", int'(iss_gtag), 0);
                if (cpl_valid) begin
                    chk("R3 unit id", int'(cpl_unit), int'(map_m[cpl_gtag][11:8]));
                    chk("R3 local tag", int'(cpl_ltag), int'(map_m[cpl_gtag][7:0]));
                    if (cpl_last) begin
                        out_bm[cpl_gtag] = 1'b0;
                        free_q.push_back(int'(cpl_gtag));
                    end
                end
            end
        end
    end

    // Driver tasks: all start and end just after a falling edge
    task automatic do_read(input int unit, input int ltag, input int len,
                           input string what, output int gtag);
        int waited;
        waited = 0;
        req_q.push_back({unit[3:0], ltag[7:0]});
        up_valid = 1'b1; up_is_read = 1'b1;
        up_unit = unit[3:0]; up_ltag = ltag[7:0]; up_len = len[6:0];
        #3;
        while (!up_ready && waited < 50) begin
            @(negedge clk); #3; waited++;
        end
        chk(what, waited, 0);
        gtag = int'(iss_gtag);
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic send_cpl(input int g, input bit last);
        cpl_valid = 1'b1; cpl_gtag = g[4:0]; cpl_last = last;
        @(negedge clk);
        cpl_valid = 1'b0; cpl_last = 1'b0;
    endtask

    task automatic give(input int w);
        rel_valid = 1'b1; rel_words = w[6:0];
        @(negedge clk);
        rel_valid = 1'b0;
    endtask

    task automatic probe(input int len, input bit is_rd, input int exp, input string what);
        up_valid = 1'b0; up_is_read = is_rd; up_len = len[6:0];
        #3;
        chk(what, int'(up_ready), exp);
        @(negedge clk);
    endtask

    task automatic drain_all();
        for (int t = 0; t < TAGS; t++)
            if (out_bm[t]) send_cpl(t, 1'b1);
    endtask

    // Watchdog
    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int g;
        repeat (3) @(negedge clk);
        #3;
        chk("R1 ready in reset", int'(up_ready), 0);
        chk("R1 no issue in reset", int'(iss_valid), 0);
        @(negedge clk);
        rst_n = 1'b1; up_is_read = 1'b1; up_len = 7'd1;
        for (int j = 0; j <= TAGS; j++) begin
            #3;
            if (j == 0 || j == TAGS - 1) chk("R1 ready during fill", int'(up_ready), 0);
            if (j == TAGS) chk("R1 ready after fill", int'(up_ready), 1);
            @(negedge clk);
        end

        // R5: write passes through
        up_valid = 1'b1; up_is_read = 1'b0; up_len = 7'd50;
        #3;
        chk("R5 write accepted", int'(up_ready), 1);
        chk("R5 write gtag zero", int'(iss_gtag), 0);
        @(negedge clk);
        up_valid = 1'b0;

        // R2/R3: same local tag from two units
        do_read(1, 5, 2, "R2 read a accepted", g);
        chk("R5 first read still gets tag 0", g, 0);
        do_read(2, 5, 2, "R2 read b accepted", g);
        chk("R2 second tag", g, 1);
        do_read(3, 9, 2, "R2 read c accepted", g);
        chk("R2 third tag", g, 2);
        send_cpl(1, 1'b0);
        send_cpl(1, 1'b1);
        send_cpl(0, 1'b1);
        send_cpl(2, 1'b1);
        give(6);

        // R6/R4: exhaust all tags
        for (int i = 0; i < TAGS; i++)
            do_read(i % 16, i + 32, 1, "R2 fill all tags", g);
        probe(1, 1'b1, 0, "R6 stall with no free tag");
        probe(1, 1'b0, 1, "R5 write open while tags exhausted");
        send_cpl(7, 1'b0);
        probe(1, 1'b1, 0, "R4 non-last part keeps tag");
        send_cpl(7, 1'b1);
        probe(1, 1'b1, 1, "R4 ready after last part");
        do_read(9, 77, 1, "R4 reissue accepted", g);
        chk("R4 freed tag reused", g, 7);
        drain_all();
        give(33);

        // R7/R8: credit boundaries
        probe(65, 1'b1, 0, "R7 oversize read stalls");
        do_read(4, 1, 64, "R8 exact credit accepted", g);
        probe(1, 1'b1, 0, "R7 stall with zero credit");
        probe(1, 1'b0, 1, "R5 write open with zero credit");
        rel_valid = 1'b1; rel_words = 7'd1;
        probe(1, 1'b1, 0, "R7 release not visible same cycle");
        rel_valid = 1'b0;
        probe(1, 1'b1, 1, "R7 release visible next cycle");
        do_read(4, 2, 1, "R8 single word credit accepted", g);
        probe(1, 1'b1, 0, "R7 credit consumed again");
        drain_all();
        give(64);
        probe(64, 1'b1, 1, "R7 full credit restored");

        repeat (2) @(negedge clk);
        chk("R2 all requests issued", req_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule